// File: doc/BRIEF.md
# Interrupt Pointer Swap Controller

This block handles the entry to and the exit from an interrupt without any stack. Entering an interrupt exchanges the 16-bit instruction pointer with a saved-vector register, so the pointer jumps to the handler and the vector register keeps the return address. Leaving the interrupt performs the same exchange in the other direction. An in-interrupt flag is set or cleared as part of the exchange.

The block decodes a small set of single-byte control opcodes. These are a software interrupt, a return from interrupt, an interrupt enable, an interrupt disable and a no-operation. It ignores every other opcode. An external interrupt request is taken on an idle cycle, which marks an instruction boundary, but only while interrupts are enabled and no interrupt is already active. After each operation it handles, the block raises a one-cycle next-fetch strobe, and the instruction pointer then holds the address to fetch from.

Top module: `intr_swap_ctrl`

## Requirements
- R1: After reset, `in_irq` and `irq_en` are 0, `ip` is 0x0000, `vec` equals the parameter `VEC_RESET`, and `fetch_next` is 0.
- R2: Opcode 0xF3 (software interrupt) with `op_valid` sets `in_irq` to 1. In the same clock edge, `ip` takes the old `vec` and `vec` takes the old `ip` plus one.
- R3: Opcode 0xF4 (return from interrupt) with `op_valid` clears `in_irq` to 0. In the same clock edge, `ip` takes the old `vec` and `vec` takes the old `ip` plus one.
- R4: Opcode 0xF5 sets `irq_en` to 1 and opcode 0xF6 clears it. Both advance `ip` by one and leave `vec` and `in_irq` unchanged.
- R5: Opcode 0xFF advances `ip` by one and changes nothing else.
- R6: `fetch_next` is 1 for exactly the one cycle after a handled operation (R2 to R5, R8), and 0 otherwise. While it is high, `ip` holds the address of the next fetch.
- R7: With `op_valid` high, any opcode other than 0xF3, 0xF4, 0xF5, 0xF6 and 0xFF leaves `ip`, `vec`, `in_irq` and `irq_en` unchanged and does not raise `fetch_next`.
- R8: An external request is taken when `irq_req` is 1, `op_valid` is 0, `irq_en` is 1 and `in_irq` is 0. It sets `in_irq`, `ip` takes the old `vec` and `vec` takes the old `ip` unchanged. In any other case `irq_req` has no effect.
- R9: When `op_valid` and `irq_req` are high in the same cycle, the opcode is executed and the request is not taken in that cycle.
- R10: Advancing `ip` from 0xFFFF wraps it to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies `opcode` this cycle |
| opcode | input | 8 | Opcode byte |
| irq_req | input | 1 | External interrupt request |
| ip | output | 16 | Current instruction pointer |
| vec | output | 16 | Saved-vector register |
| in_irq | output | 1 | In-interrupt flag |
| irq_en | output | 1 | Interrupt-enable flag |
| fetch_next | output | 1 | Next-fetch strobe |

## Verification
The bench goes after several corner cases, each of which has a distinct failure signature:
- A request raised while interrupts are disabled, or while a handler is already running. A design that ignored either gating condition would jump to the vector a second time and lose the return address.
- A request arriving in the same cycle as an opcode. A wrong priority would drop or corrupt the instruction.
- Unlisted opcodes next to the handled ones, such as 0xF7 and 0x00. A loose decode would advance the pointer or raise the strobe on them.
- A pointer that advances past 0xFFFF, and a swap whose saved value is off by one. Either fault would resume the program at the wrong address after a return.

// File: rtl/intr_swap_ctrl.sv
module intr_swap_ctrl #(
  parameter int IP_W = 16,
  parameter int OP_W = 8,
  parameter logic [IP_W-1:0] VEC_RESET = 16'h0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] opcode,
  input  logic            irq_req,
  output logic [IP_W-1:0] ip,
  output logic [IP_W-1:0] vec,
  output logic            in_irq,
  output logic            irq_en,
  output logic            fetch_next
);

  localparam logic [OP_W-1:0] OP_SWI = OP_W'(8'hF3);
  localparam logic [OP_W-1:0] OP_RTI = OP_W'(8'hF4);
  localparam logic [OP_W-1:0] OP_IEN = OP_W'(8'hF5);
  localparam logic [OP_W-1:0] OP_IDI = OP_W'(8'hF6);
  localparam logic [OP_W-1:0] OP_NOP = OP_W'(8'hFF);

  logic do_swi, do_rti, do_ien, do_idi, do_nop, do_swap, do_step, irq_take;
  logic [IP_W-1:0] ip_inc;

  assign do_swi   = op_valid && (opcode == OP_SWI);
  assign do_rti   = op_valid && (opcode == OP_RTI);
  assign do_ien   = op_valid && (opcode == OP_IEN);
  assign do_idi   = op_valid && (opcode == OP_IDI);
  assign do_nop   = op_valid && (opcode == OP_NOP);
  assign do_swap  = do_swi || do_rti;
  assign do_step  = do_ien || do_idi || do_nop;
  assign irq_take = irq_req && !op_valid && irq_en && !in_irq;
  assign ip_inc   = ip + IP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip         <= '0;
      vec        <= VEC_RESET;
      in_irq     <= 1'b0;
      irq_en     <= 1'b0;
      fetch_next <= 1'b0;
    end else begin
      fetch_next <= do_swap || do_step || irq_take;
      if (do_swap) begin
        ip     <= vec;
        vec    <= ip_inc;
        in_irq <= do_swi;
      end else if (do_step) begin
        ip <= ip_inc;
        if (do_ien) irq_en <= 1'b1;
        if (do_idi) irq_en <= 1'b0;
      end else if (irq_take) begin
        ip     <= vec;
        vec    <= ip;
        in_irq <= 1'b1;
      end
    end
  end

  assert_swi_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_SWI) |=>
      (in_irq && ip == $past(vec) && vec == $past(ip) + IP_W'(1)));

  assert_rti_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_RTI) |=>
      (!in_irq && ip == $past(vec) && vec == $past(ip) + IP_W'(1)));

  assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (opcode == OP_IEN || opcode == OP_IDI)) |=>
      (irq_en == ($past(opcode) == OP_IEN) && $stable(vec) && $stable(in_irq)));

  assert_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_next |-> ($past(op_valid) || $past(irq_req)));

  assert_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode != OP_SWI && opcode != OP_RTI && opcode != OP_IEN &&
     opcode != OP_IDI && opcode != OP_NOP) |=>
      ($stable(ip) && $stable(vec) && $stable(in_irq) && $stable(irq_en) && !fetch_next));

  assert_irq_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && (in_irq || !irq_en)) |=> ($stable(ip) && $stable(vec)));

  assert_irq_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !op_valid && irq_en && !in_irq) |=>
      (in_irq && ip == $past(vec) && vec == $past(ip)));

  assert_opcode_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_NOP) |=> (ip == $past(ip) + IP_W'(1) && $stable(in_irq)));

endmodule

// File: tb/test_intr_swap_ctrl.sv
module test_intr_swap_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic irq_req = 1'b0;
  logic [15:0] ip, vec;
  logic in_irq, irq_en, fetch_next;

  always #2.5 clk = ~clk;

  intr_swap_ctrl #(.VEC_RESET(16'hFFFE)) i_intr_swap_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .irq_req(irq_req), .ip(ip), .vec(vec), .in_irq(in_irq),
    .irq_en(irq_en), .fetch_next(fetch_next)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  string m_req = "R1";
  logic [15:0] m_ip = 16'h0000, m_vec = 16'hFFFE;
  logic m_in = 1'b0, m_en = 1'b0, m_fetch = 1'b0;
  logic running = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (running) begin
      m_req = cur_req;
      m_fetch = 1'b0;
      if (op_valid) begin
        case (opcode)
          8'hF3, 8'hF4: begin
            logic [15:0] t;
            t = m_ip;
            m_ip = m_vec;
            m_vec = t + 16'd1;
            m_in = (opcode == 8'hF3);
            m_fetch = 1'b1;
          end
          8'hF5: begin m_en = 1'b1; m_ip = m_ip + 16'd1; m_fetch = 1'b1; end
          8'hF6: begin m_en = 1'b0; m_ip = m_ip + 16'd1; m_fetch = 1'b1; end
          8'hFF: begin m_ip = m_ip + 16'd1; m_fetch = 1'b1; end
          default: ;
        endcase
      end else if (irq_req && m_en && !m_in) begin
        logic [15:0] t;
        t = m_ip;
        m_ip = m_vec;
        m_vec = t;
        m_in = 1'b1;
        m_fetch = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      chk(m_req, "ip", ip, m_ip);
      chk(m_req, "vec", vec, m_vec);
      chk(m_req, "in_irq", in_irq, m_in);
      chk(m_req, "irq_en", irq_en, m_en);
      chk(m_req, "fetch_next R6", fetch_next, m_fetch);
    end
  end

  task automatic step(logic v, logic [7:0] op, logic rq, string req);
    @(negedge clk);
    op_valid = v;
    opcode = op;
    irq_req = rq;
    cur_req = req;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ip", ip, 16'h0000);
    chk("R1", "vec", vec, 16'hFFFE);
    chk("R1", "in_irq", in_irq, 0);
    chk("R1", "irq_en", irq_en, 0);
    chk("R1", "fetch_next", fetch_next, 0);
    rst_n = 1'b1;
    running = 1'b1;
    step(1, 8'hFF, 0, "R5");
    step(1, 8'hFF, 0, "R5");
    step(0, 8'h00, 0, "R6");
    step(1, 8'h00, 0, "R7");
    step(1, 8'hF7, 0, "R7");
    step(1, 8'hF2, 0, "R7");
    step(0, 8'h00, 1, "R8");
    step(1, 8'hF5, 0, "R4");
    step(0, 8'h00, 1, "R8");
    step(0, 8'h00, 1, "R8");
    step(1, 8'hFF, 0, "R10");
    step(1, 8'hFF, 0, "R10");
    step(1, 8'hF4, 0, "R3");
    step(1, 8'hF6, 0, "R4");
    step(1, 8'hF3, 0, "R2");
    step(1, 8'hF4, 0, "R3");
    step(1, 8'hF5, 0, "R4");
    step(1, 8'hFF, 1, "R9");
    step(1, 8'hF3, 1, "R9");
    step(0, 8'h00, 1, "R8");
    step(1, 8'hF4, 0, "R3");
    step(0, 8'h00, 1, "R8");
    step(0, 8'h00, 0, "R6");
    for (int k = 0; k < 60; k++) begin
      logic [7:0] ops [6];
      ops = '{8'hF3, 8'hFF, 8'hF4, 8'hF6, 8'hF5, 8'h7A};
      step((k % 3) != 2, ops[k % 6], (k % 4) == 1, "R2");
    end
    step(0, 8'h00, 0, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule